// File: doc/BRIEF.md
# Periodic Program-Counter Sampler

This block runs beside a processor core and produces statistical profiling data with no help from software. A free-running cycle counter drives an interval down-counter. The down-counter steps once each time a chosen low bit of the cycle counter changes value. When the down-counter passes below zero, it reloads. If sampling is enabled, the block also captures the core's current program counter and offers it as a PC-sample request. If the core is asleep at that moment, the request carries a sleep flag instead of an address.

The same cycle counter also supplies periodic synchronisation requests from one of three selectable high bits. Both kinds of request leave through a single valid/ready port that carries a one-bit packet kind, a 32-bit payload and the sleep flag. A downstream packetiser or trace link turns these requests into bytes. A sample that arrives while an earlier sample is still waiting is discarded, and the block records the loss in a sticky flag.

Top module: `pcs_profiler_top`

## Requirements
- R1: While `rst` is high at a clock edge, the cycle counter clears, the interval counter loads `post_init`, and all pending requests are discarded. After that edge, `req_valid` and `ovf_flag` read 0.
- R2: The interval counter steps once per change of the selected cycle-counter bit. With `post_tap_sel`=0 this is bit 6, so one step every 64 enabled cycles. With `post_tap_sel`=1 this is bit 10, so one step every 1024 enabled cycles.
- R3: A step taken while the interval counter is 0 is an underflow and reloads `post_reload`. Any other step decrements the counter. After reset, the first underflow therefore comes at step `post_init`+1, and each later underflow comes `post_reload`+1 steps after the previous one.
- R4: An underflow with `pc_samp_en`=1 creates a request with kind 0 (PC sample) whose payload is the value of `pc_in` in the underflow cycle. The request becomes visible on the next cycle. With `pc_samp_en`=0, an underflow creates no request.
- R5: If `core_sleep` is 1 in the underflow cycle, the PC-sample request has `req_sleep`=1 and a payload of zero.
- R6: `sync_sel` selects the synchronisation period: 0 gives none, and 1, 2 or 3 give one request per change of cycle-counter bit SYNC_LO, SYNC_LO+2 or SYNC_LO+4 respectively (default SYNC_LO=24). A sync request has kind 1, payload 0 and `req_sleep`=0.
- R7: While `cyc_en` is 0, the cycle counter and the interval counter hold their values and no new request of either kind appears.
- R8: Once offered, a request stays valid with unchanged kind, payload and sleep flag until `req_ready` accepts it. When the port is free and both kinds are pending, the sync request is offered first.
- R9: A PC sample that arrives while an earlier PC sample is pending and not being accepted in that same cycle is dropped. The earlier sample is kept unchanged, and `ovf_flag` is set and stays 1 until reset.
- R10: A sync event while a sync request is already pending merges into that request. Only one sync request is delivered, and `ovf_flag` is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_en | input | 1 | Cycle counter enable |
| pc_samp_en | input | 1 | PC sampling enable |
| post_tap_sel | input | 1 | Interval tap: 0 = bit 6, 1 = bit 10 |
| sync_sel | input | 2 | Sync period select |
| post_init | input | POST_W | Interval counter value loaded at reset |
| post_reload | input | POST_W | Interval counter value loaded at underflow |
| pc_in | input | 32 | Current program counter of the core |
| core_sleep | input | 1 | Core is idle/asleep |
| req_valid | output | 1 | Request offered |
| req_ready | input | 1 | Downstream accepts the request |
| req_kind | output | 1 | 0 = PC sample, 1 = sync |
| req_payload | output | 32 | Sampled PC, or zero |
| req_sleep | output | 1 | Sample taken while the core slept |
| ovf_flag | output | 1 | Sticky: a sample was dropped |

## Verification
A wrong interval count or tap decode shows up at the ports as a PC-sample request that is early, late or missing. It becomes visible within one tap period (64 or 1024 cycles) multiplied by the reload distance, and the per-cycle comparison with the bench's reference catches it on the first cycle where `req_valid` differs. Damaged snapshot or selection state shows up in the payload, sleep flag or kind on the cycle the request is offered. A wrong drop or merge policy shows up as a stray `ovf_flag` or an extra or missing request once the stalled port drains.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

    localparam int PC_W     = 32;
    localparam int NUM_SYNC = 3;
    localparam int SYNC_GAP = 2;

    typedef enum logic {
        PKT_PC   = 1'b0,
        PKT_SYNC = 1'b1
    } pkt_kind_e;

    typedef struct packed {
        logic            asleep;
        logic [PC_W-1:0] addr;
    } pc_snap_t;

    // Address shown on the port for a captured snapshot
    function automatic logic [PC_W-1:0] snap_payload(input pc_snap_t s);
        return s.asleep ? '0 : s.addr;
    endfunction

endpackage

// File: rtl/pcs_cycle_timer.sv
module pcs_cycle_timer
    import pcs_pkg::*;
#(
    parameter int POST_TAP_LO = 6,
    parameter int POST_TAP_HI = 10,
    parameter int SYNC_LO     = 24
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       post_sel,
    input  logic [1:0] sync_sel,
    output logic       post_tick,
    output logic       sync_tick
);
    // Highest tap toggles when all bits below it are ones; no wider count is needed
    localparam int CNT_W = SYNC_LO + SYNC_GAP * (NUM_SYNC - 1);

    logic [CNT_W-1:0]    cnt_q;
    logic [NUM_SYNC-1:0] sync_hit;
    logic                post_hit_lo;
    logic                post_hit_hi;
    logic                sync_pick;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (en)
            cnt_q <= cnt_q + 1'b1;
    end

    // A tap bit changes on the next increment exactly when all lower bits are ones
    assign post_hit_lo = &cnt_q[POST_TAP_LO-1:0];
    assign post_hit_hi = &cnt_q[POST_TAP_HI-1:0];

    generate
        for (genvar g = 0; g < NUM_SYNC; g++) begin : g_sync_tap
            localparam int TAP = SYNC_LO + SYNC_GAP * g;
            assign sync_hit[g] = &cnt_q[TAP-1:0];
        end
    endgenerate

    always_comb begin
        case (sync_sel)
            2'd1:    sync_pick = sync_hit[0];
            2'd2:    sync_pick = sync_hit[1];
            2'd3:    sync_pick = sync_hit[2];
            default: sync_pick = 1'b0;
        endcase
    end

    assign post_tick = en && (post_sel ? post_hit_hi : post_hit_lo);
    assign sync_tick = en && sync_pick;

endmodule

// File: rtl/pcs_interval_down.sv
module pcs_interval_down #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] init_val,
    input  logic [W-1:0] reload_val,
    input  logic         step,
    output logic         underflow,
    output logic [W-1:0] count
);
    logic [W-1:0] cnt_q;

    assign underflow = step && (cnt_q == '0);
    assign count     = cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= init_val;
        else if (step)
            cnt_q <= underflow ? reload_val : cnt_q - 1'b1;
    end

endmodule

// File: rtl/pcs_req_slots.sv
module pcs_req_slots
    import pcs_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            samp_evt,
    input  pc_snap_t        samp_in,
    input  logic            sync_evt,
    input  logic            ready,
    output logic            valid,
    output pkt_kind_e       kind,
    output logic [PC_W-1:0] payload,
    output logic            asleep,
    output logic            ovf
);
    logic      samp_v_q, samp_v_n;
    pc_snap_t  snap_q, snap_n;
    logic      sync_q, sync_n;
    pkt_kind_e sel_q, sel_n;
    logic      ovf_q, ovf_n;
    logic      hold, acc_pc, acc_sync;

    assign valid   = samp_v_q | sync_q;
    assign kind    = sel_q;
    assign payload = (sel_q == PKT_SYNC) ? '0 : snap_payload(snap_q);
    assign asleep  = (sel_q == PKT_PC) && snap_q.asleep;
    assign ovf     = ovf_q;

    assign hold     = valid && !ready;
    assign acc_pc   = valid && ready && (sel_q == PKT_PC);
    assign acc_sync = valid && ready && (sel_q == PKT_SYNC);

    always_comb begin
        samp_v_n = samp_v_q && !acc_pc;
        snap_n   = snap_q;
        ovf_n    = ovf_q;
        if (samp_evt) begin
            if (samp_v_n) begin
                ovf_n = 1'b1;
            end else begin
                samp_v_n = 1'b1;
                snap_n   = samp_in;
            end
        end
        sync_n = (sync_q && !acc_sync) || sync_evt;
        // Keep a stalled offer in place; otherwise sync goes first
        if (hold)
            sel_n = sel_q;
        else
            sel_n = sync_n ? PKT_SYNC : PKT_PC;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            samp_v_q <= 1'b0;
            snap_q   <= '0;
            sync_q   <= 1'b0;
            sel_q    <= PKT_PC;
            ovf_q    <= 1'b0;
        end else begin
            samp_v_q <= samp_v_n;
            snap_q   <= snap_n;
            sync_q   <= sync_n;
            sel_q    <= sel_n;
            ovf_q    <= ovf_n;
        end
    end

endmodule

// File: rtl/pcs_profiler_top.sv
module pcs_profiler_top
    import pcs_pkg::*;
#(
    parameter int POST_W      = 4,
    parameter int POST_TAP_LO = 6,
    parameter int POST_TAP_HI = 10,
    parameter int SYNC_LO     = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cyc_en,
    input  logic              pc_samp_en,
    input  logic              post_tap_sel,
    input  logic [1:0]        sync_sel,
    input  logic [POST_W-1:0] post_init,
    input  logic [POST_W-1:0] post_reload,
    input  logic [PC_W-1:0]   pc_in,
    input  logic              core_sleep,
    output logic              req_valid,
    input  logic              req_ready,
    output logic              req_kind,
    output logic [PC_W-1:0]   req_payload,
    output logic              req_sleep,
    output logic              ovf_flag
);
    logic              post_tick;
    logic              sync_tick;
    logic              underflow;
    logic [POST_W-1:0] post_cnt;
    pc_snap_t          snap;
    pkt_kind_e         kind_w;

    pcs_cycle_timer #(
        .POST_TAP_LO (POST_TAP_LO),
        .POST_TAP_HI (POST_TAP_HI),
        .SYNC_LO     (SYNC_LO)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .en        (cyc_en),
        .post_sel  (post_tap_sel),
        .sync_sel  (sync_sel),
        .post_tick (post_tick),
        .sync_tick (sync_tick)
    );

    pcs_interval_down #(
        .W (POST_W)
    ) u_interval (
        .clk        (clk),
        .rst        (rst),
        .init_val   (post_init),
        .reload_val (post_reload),
        .step       (post_tick),
        .underflow  (underflow),
        .count      (post_cnt)
    );

    assign snap.asleep = core_sleep;
    assign snap.addr   = pc_in;

    pcs_req_slots u_slots (
        .clk      (clk),
        .rst      (rst),
        .samp_evt (underflow && pc_samp_en),
        .samp_in  (snap),
        .sync_evt (sync_tick),
        .ready    (req_ready),
        .valid    (req_valid),
        .kind     (kind_w),
        .payload  (req_payload),
        .asleep   (req_sleep),
        .ovf      (ovf_flag)
    );

    assign req_kind = kind_w;

endmodule

// File: rtl/pcs_profiler_chk.sv
module pcs_profiler_chk #(
    parameter int POST_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              cyc_en,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_kind,
    input logic [31:0]       req_payload,
    input logic              req_sleep,
    input logic              ovf_flag,
    input logic [POST_W-1:0] post_cnt
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> !req_valid && !ovf_flag);

    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_ready |=> req_valid && $stable(req_kind)
                                    && $stable(req_payload) && $stable(req_sleep));

    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_flag |=> ovf_flag);

    // R5
    sleep_zero_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_sleep |-> req_payload == 32'd0 && !req_kind);

    // R6
    sync_fields_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_kind |-> req_payload == 32'd0 && !req_sleep);

    // R7
    halt_count_chk: assert property (@(posedge clk) disable iff (rst)
        !cyc_en |=> $stable(post_cnt));

    // R7
    halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !cyc_en && !req_valid |=> !req_valid);

endmodule

bind pcs_profiler_top pcs_profiler_chk #(
    .POST_W (POST_W)
) u_pcs_chk (
    .clk         (clk),
    .rst         (rst),
    .cyc_en      (cyc_en),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_kind    (req_kind),
    .req_payload (req_payload),
    .req_sleep   (req_sleep),
    .ovf_flag    (ovf_flag),
    .post_cnt    (post_cnt)
);

// File: tb/test_pcs_profiler_top.sv
module test_pcs_profiler_top;
    localparam int SYNC_LO = 12;
    localparam int POST_W  = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cyc_en = 1'b1;
    logic              pc_samp_en = 1'b1;
    logic              post_tap_sel = 1'b0;
    logic [1:0]        sync_sel = 2'd0;
    logic [POST_W-1:0] post_init = '0;
    logic [POST_W-1:0] post_reload = '0;
    logic [31:0]       pc_in = 32'h0800_0000;
    logic              core_sleep = 1'b0;
    logic              req_valid;
    logic              req_ready = 1'b1;
    logic              req_kind;
    logic [31:0]       req_payload;
    logic              req_sleep;
    logic              ovf_flag;

    always #4 clk = ~clk;

    pcs_profiler_top #(
        .POST_W  (POST_W),
        .SYNC_LO (SYNC_LO)
    ) i_pcs_profiler_top (
        .clk          (clk),
        .rst          (rst),
        .cyc_en       (cyc_en),
        .pc_samp_en   (pc_samp_en),
        .post_tap_sel (post_tap_sel),
        .sync_sel     (sync_sel),
        .post_init    (post_init),
        .post_reload  (post_reload),
        .pc_in        (pc_in),
        .core_sleep   (core_sleep),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_kind     (req_kind),
        .req_payload  (req_payload),
        .req_sleep    (req_sleep),
        .ovf_flag     (ovf_flag)
    );

    int    vectors = 0;
    int    fails   = 0;
    bit    finished = 0;
    string cur_req = "R4";
    bit    rand_ready = 0;
    bit    rand_sleep = 0;

    // reference model state
    int unsigned m_cyc;
    logic [POST_W-1:0] m_post;
    bit          m_sv, m_sl, m_sy, m_sel, m_ovf;
    logic [31:0] m_pc;

    // accepted requests counted at the DUT port
    int n_pc, n_sync, n_sleep;

    function automatic bit hit(int unsigned c, int b);
        int unsigned m;
        m = (32'd1 << b) - 32'd1;
        return (c & m) == m;
    endfunction

    task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", r, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        bit v, acc, hold, tp, und, se, ye;
        int b;
        if (!rst && req_valid && req_ready) begin
            if (req_kind) n_sync++;
            else begin
                n_pc++;
                if (req_sleep) n_sleep++;
            end
        end
        if (rst) begin
            m_cyc = 0; m_post = post_init; m_sv = 0; m_sy = 0; m_sel = 0; m_ovf = 0;
            m_sl = 0; m_pc = 0;
        end else begin
            v    = m_sv || m_sy;
            acc  = v && req_ready;
            hold = v && !req_ready;
            b    = post_tap_sel ? 10 : 6;
            tp   = cyc_en && hit(m_cyc, b);
            und  = tp && (m_post == 0);
            if (tp) m_post = und ? post_reload : m_post - 1'b1;
            se = und && pc_samp_en;
            ye = cyc_en && (sync_sel != 0) && hit(m_cyc, SYNC_LO + 2 * (int'(sync_sel) - 1));
            if (acc && !m_sel) m_sv = 0;
            if (se) begin
                if (m_sv) m_ovf = 1;
                else begin m_sv = 1; m_pc = pc_in; m_sl = core_sleep; end
            end
            if (acc && m_sel) m_sy = 0;
            if (ye) m_sy = 1;
            if (!hold) m_sel = m_sy;
            if (cyc_en) m_cyc++;
        end
    end

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk(cur_req, {31'd0, req_valid}, {31'd0, m_sv || m_sy});
            if (req_valid && (m_sv || m_sy)) begin
                chk("R8", {31'd0, req_kind}, {31'd0, m_sel});
                chk(m_sel ? "R6" : "R4", req_payload, m_sel ? 32'd0 : (m_sl ? 32'd0 : m_pc));
                chk("R5", {31'd0, req_sleep}, {31'd0, !m_sel && m_sl});
            end
            chk("R9", {31'd0, ovf_flag}, {31'd0, m_ovf});
        end
    end

    task automatic run(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            pc_in = pc_in + 32'h0000_0026;
            if (rand_ready) req_ready = ($urandom % 4) != 0;
            if (rand_sleep) core_sleep = ($urandom % 3) == 0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        n_pc = 0; n_sync = 0; n_sleep = 0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            finished = 1;
            summary();
            $finish;
        end
    end

    initial begin
        // R1: state after reset
        post_init = 4'd2; post_reload = 4'd3;
        do_reset();
        #1;
        chk("R1", {31'd0, req_valid}, 32'd0);
        chk("R1", {31'd0, ovf_flag}, 32'd0);

        // R3: init 2 then reload 3 on tap bit 6, 2000 cycles -> 8 samples
        cur_req = "R3";
        run(2000);
        chk("R3", n_pc, 8);

        // R2: tap bit 10, init 0 reload 1, 5000 cycles -> 2 samples
        cur_req = "R2";
        post_tap_sel = 1'b1; post_init = 4'd0; post_reload = 4'd1;
        do_reset();
        run(5000);
        chk("R2", n_pc, 2);

        // R5: sleep flag replaces the address
        cur_req = "R5";
        post_tap_sel = 1'b0; post_init = 4'd0; post_reload = 4'd0;
        rand_sleep = 1;
        do_reset();
        run(1500);
        rand_sleep = 0; core_sleep = 1'b0;
        chk("R4", n_pc, 23);
        chk("R5", {31'd0, n_sleep > 0 && n_sleep < 23}, 32'd1);

        // R4: sampling disabled gives no requests
        cur_req = "R4";
        pc_samp_en = 1'b0;
        do_reset();
        run(700);
        chk("R4", n_pc, 0);
        pc_samp_en = 1'b1;

        // R9: stalled port drops later samples and sets the sticky flag
        cur_req = "R9";
        req_ready = 1'b0;
        do_reset();
        run(200);
        chk("R9", {31'd0, ovf_flag}, 32'd1);
        chk("R9", {31'd0, req_valid}, 32'd1);
        req_ready = 1'b1;
        run(10);
        chk("R9", n_pc, 1);
        chk("R9", {31'd0, ovf_flag}, 32'd1);

        // R6: sync periods
        cur_req = "R6";
        pc_samp_en = 1'b0; sync_sel = 2'd1;
        do_reset();
        run(9000);
        chk("R6", n_sync, 2);
        sync_sel = 2'd0;
        do_reset();
        run(9000);
        chk("R6", n_sync, 0);
        sync_sel = 2'd2;
        do_reset();
        run(17000);
        chk("R6", n_sync, 1);

        // R10: repeated sync while stalled merges into one
        cur_req = "R10";
        sync_sel = 2'd1; req_ready = 1'b0;
        do_reset();
        run(9000);
        req_ready = 1'b1;
        run(5);
        chk("R10", n_sync, 1);
        chk("R10", {31'd0, ovf_flag}, 32'd0);

        // R7: counter disabled freezes everything
        cur_req = "R7";
        pc_samp_en = 1'b1; cyc_en = 1'b0;
        do_reset();
        run(5000);
        chk("R7", n_pc, 0);
        chk("R7", n_sync, 0);
        cyc_en = 1'b1;
        run(100);
        chk("R7", n_pc, 1);

        // R8: random back-pressure, mixed kinds, tap changes
        cur_req = "R8";
        post_init = 4'd1; post_reload = 4'd0; sync_sel = 2'd1;
        rand_ready = 1; rand_sleep = 1;
        do_reset();
        run(15000);
        post_tap_sel = 1'b1;
        run(8000);
        post_tap_sel = 1'b0; post_reload = 4'd2;
        run(7000);
        chk("R8", {31'd0, n_sync > 0 && n_pc > 0}, 32'd1);

        finished = 1;
        summary();
        $finish;
    end

endmodule